// File: doc/BRIEF.md
# Detector ADC Conversion Controller

This block runs one 8-bit conversion of a power-detector ADC at a time, driven by a small set of control bits. Firmware sets the enable, clock-enable and start bits. The controller then waits a fixed number of clock cycles and latches the converter's sample bus. It publishes the latched byte together with a done flag in a 9-bit result word. After firmware has seen the done flag it lowers start, reads the word again, and later raises start to request another conversion.

The register file outside this block owns the addressing. The controller sees the control field and the result word as plain ports. The analog converter is modelled by the `sample_in` bus, which is taken at the last cycle of the conversion window. The default window of 10000 cycles is about 200 microseconds at a 50 MHz clock.

Top module: `det_adc_seq`

## Requirements
- R1: After reset the result word is all zeros: done flag (bit 8) is 0 and value (bits 7:0) is 0x00.
- R2: A conversion begins only on a clock edge where start (control bit 2) is 1 after being 0 on the previous edge, and clock-enable (bit 0) and enable (bit 1) are both 1 on that same edge. Raising start while either enable is 0 starts nothing, and enabling later with start still high starts nothing.
- R3: If a conversion begins at edge k, then at edge k+CONV_CYCLES the done flag becomes 1 and bits 7:0 take the value of `sample_in` at that edge.
- R4: While a conversion is running, the done flag reads 0.
- R5: Once done, the result word holds steady while start stays high and across the falling edge of start. Holding start high never starts another conversion.
- R6: Clearing enable or clock-enable during a conversion aborts it. The done flag stays 0, and a new conversion needs a fresh rising edge of start.
- R7: The done flag clears on the edge after a new conversion begins. It also clears on the first edge where enable or clock-enable is 0.
- R8: Control bit 3, the detector output routing select, has no effect on the conversion or on the result word.
- R9: If enable or clock-enable drops on the same edge that would end the conversion, the abort wins and no result is published.
- R10: Bits 7:0 keep the last captured value until the next capture, even after the done flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 4 | Control field: bit 0 clock-enable, bit 1 enable, bit 2 start, bit 3 routing select |
| sample_in | input | DATA_W | Converter sample bus, taken at the end of the window |
| res_word | output | DATA_W+1 | Bit DATA_W is the done flag; the low DATA_W bits are the value |

## Verification
Two events can land on the same edge: the final count of the conversion window and the loss of enable or clock-enable. The bench sets up that clash by clearing clock-enable on the input setup just before the edge that would complete the conversion. It then expects the done flag to stay low and the value field to keep the older result. A reference model in the bench tracks the remaining window as a down-counter. The model is compared with the result word on every clock, so a wrong priority between completion and abort shows up on the exact cycle where it occurs.

// File: rtl/det_adc_pkg.sv
package det_adc_pkg;

  localparam int unsigned CTL_W          = 4;
  localparam int unsigned CTL_CLK_EN_BIT = 0;
  localparam int unsigned CTL_ADC_EN_BIT = 1;
  localparam int unsigned CTL_START_BIT  = 2;
  localparam int unsigned CTL_ROUTE_BIT  = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_t;

  // Both enables must be high for the converter to run.
  function automatic logic gate_open(logic [CTL_W-1:0] ctl);
    return ctl[CTL_CLK_EN_BIT] & ctl[CTL_ADC_EN_BIT];
  endfunction

  // True on the last counter value of a window of `cycles` edges.
  function automatic logic count_at_end(int unsigned cnt, int unsigned cycles);
    return cnt == (cycles - 1);
  endfunction

endpackage

// File: rtl/det_adc_edge.sv
module det_adc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  output logic start_rise
);

  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_in;
  end

  assign start_rise = start_in & ~start_q;

  // A level held high cannot yield two rises in a row (R5).
  assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> !start_rise);

endmodule

// File: rtl/det_adc_timer.sv
module det_adc_timer #(
  parameter int unsigned CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic at_end
);
  import det_adc_pkg::*;

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign at_end = run & count_at_end(32'(cnt_q), CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear)         cnt_q <= '0;
    else if (run && !at_end) cnt_q <= cnt_q + 1'b1;
  end

  // The counter never passes the window length (R3).
  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < CYCLES);

endmodule

// File: rtl/det_adc_result.sv
module det_adc_result #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              clear_done,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] value_out,
  output logic              done_out
);

  logic [DATA_W-1:0] value_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (capture) value_q <= sample;
      if (clear_done)   done_q <= 1'b0;
      else if (capture) done_q <= 1'b1;
    end
  end

  assign value_out = value_q;
  assign done_out  = done_q;

  // The sequencer must never publish and clear in the same cycle (R9).
  assert_capture_clear_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && clear_done));

endmodule

// File: rtl/det_adc_seq.sv
module det_adc_seq #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CONV_CYCLES = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           ctl_word,
  input  logic [DATA_W-1:0]    sample_in,
  output logic [DATA_W:0]      res_word
);
  import det_adc_pkg::*;

  seq_state_t  state_q, state_d;
  logic        gate;
  logic        start_rise;
  logic        win_end;
  logic        ev_trigger;
  logic        ev_abort;
  logic        ev_complete;
  logic        done_flag;
  logic [DATA_W-1:0] value;
  logic        unused_route;

  // Routing select only steers the analog output; the sequence ignores it (R8).
  assign unused_route = ctl_word[CTL_ROUTE_BIT];

  assign gate = gate_open(ctl_word);

  det_adc_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_in   (ctl_word[CTL_START_BIT]),
    .start_rise (start_rise)
  );

  det_adc_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q != SEQ_CONV),
    .run    ((state_q == SEQ_CONV) && gate),
    .at_end (win_end)
  );

  // Named events for the assertions.
  assign ev_trigger  = gate && start_rise && (state_q != SEQ_CONV);
  assign ev_abort    = (state_q == SEQ_CONV) && !gate;
  assign ev_complete = (state_q == SEQ_CONV) && gate && win_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (ev_trigger) state_d = SEQ_CONV;
      SEQ_CONV: begin
        if (!gate)           state_d = SEQ_IDLE;
        else if (ev_complete) state_d = SEQ_HOLD;
      end
      SEQ_HOLD: begin
        if (!gate)           state_d = SEQ_IDLE;
        else if (ev_trigger) state_d = SEQ_CONV;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  det_adc_result #(.DATA_W(DATA_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (ev_complete),
    .clear_done (ev_trigger || !gate),
    .sample     (sample_in),
    .value_out  (value),
    .done_out   (done_flag)
  );

  assign res_word = {done_flag, value};

  // R2: idle stays idle without a gated rising edge of start.
  assert_idle_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && !(start_rise && gate)) |=> state_q == SEQ_IDLE);

  // R3: done rises only out of a running conversion.
  assert_done_from_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_word[DATA_W]) |-> $past(state_q == SEQ_CONV));

  // R4: no done flag while converting.
  assert_busy_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONV) |-> !res_word[DATA_W]);

  // R5: the published word holds while gated and no new edge arrives.
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_HOLD && gate && !start_rise) |=> $stable(res_word));

  // R6: losing an enable mid-conversion returns to idle with done low.
  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (state_q == SEQ_IDLE && !res_word[DATA_W]));

  // R7: a new conversion clears the done flag on the next edge.
  assert_new_conv_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trigger |=> !res_word[DATA_W]);

endmodule

// File: tb/det_adc_seq_tb.sv
`timescale 1ns/1ps
module det_adc_seq_tb;

  localparam int N = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ctl = 4'b0000;
  logic [7:0] sample = 8'h00;
  logic [8:0] res;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  det_adc_seq #(.DATA_W(8), .CONV_CYCLES(N)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_word  (ctl),
    .sample_in (sample),
    .res_word  (res)
  );

  // Behavioural reference: a countdown of remaining edges.
  bit       m_busy = 0;
  int       m_left = 0;
  bit       m_done = 0;
  bit [7:0] m_val  = 8'h00;
  bit       m_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_done = 0; m_val = 8'h00; m_prev = 0;
    end else begin
      bit g, r;
      g = ctl[0] && ctl[1];
      r = ctl[2] && !m_prev;
      if (m_busy) begin
        if (!g) m_busy = 0;
        else begin
          m_left = m_left - 1;
          if (m_left == 0) begin
            m_busy = 0; m_done = 1; m_val = sample;
          end
        end
      end else if (g && r) begin
        m_busy = 1; m_left = N; m_done = 0;
      end else if (!g) begin
        m_done = 0;
      end
      m_prev = ctl[2];
    end
  end

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R3 R4 R7 R10).
  always @(negedge clk) begin
    if (rst_n && !finished) check("per-cycle R3 R4 R7 R10", res, {m_done, m_val});
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 reset word", res, 9'h000);

    // R2: start without enables, then enables with start already high.
    ctl = 4'b0100; tick(N + 3);
    check("R2 no gate", res, 9'h000);
    ctl = 4'b0111; tick(N + 3);
    check("R2 late gate", res, 9'h000);
    ctl = 4'b0011; tick(2);

    // R3 R4: normal conversion.
    sample = 8'hA5; ctl = 4'b0111; tick(N);
    check("R4 busy", res, 9'h000);
    tick(1);
    check("R3 done", res, 9'h1A5);

    // R5: no retrigger while held, stable across falling start.
    sample = 8'h5A; tick(5);
    check("R5 held", res, 9'h1A5);
    ctl = 4'b0011; tick(1);
    check("R5 fall", res, 9'h1A5);

    // R7 R8 R10: new conversion with routing bit toggling.
    sample = 8'h3C; ctl = 4'b1111; tick(1);
    check("R7 clear on start", res, 9'h0A5);
    ctl = 4'b0111; tick(3);
    ctl = 4'b1111; tick(N - 4);
    check("R8 busy", res, 9'h0A5);
    tick(1);
    check("R8 route ignored", res, 9'h13C);

    // R6: abort by enable loss; re-enable with start high does nothing.
    ctl = 4'b0011; tick(1);
    sample = 8'h77; ctl = 4'b0111; tick(4);
    ctl = 4'b0101; tick(1);
    check("R6 abort", res, 9'h03C);
    tick(N + 2);
    check("R6 stays aborted", res, 9'h03C);
    ctl = 4'b0111; tick(N + 2);
    check("R6 no edge no start", res, 9'h03C);

    // R7 R10: disable while done.
    ctl = 4'b0011; tick(1);
    ctl = 4'b0111; tick(N + 1);
    check("R3 second", res, 9'h177);
    ctl = 4'b0101; tick(1);
    check("R7 R10 disable", res, 9'h077);

    // R9: clock-enable drops on the completing edge.
    ctl = 4'b0011; tick(1);
    sample = 8'h99; ctl = 4'b0111; tick(N);
    check("R9 pre", res, 9'h077);
    ctl = 4'b0110; tick(1);
    check("R9 abort wins", res, 9'h077);
    tick(3);
    check("R9 after", res, 9'h077);

    // Recovery conversion.
    ctl = 4'b0011; tick(1);
    ctl = 4'b0111; tick(N + 1);
    check("R3 recovery", res, 9'h199);

    finish_run();
  end

endmodule